// File: doc/BRIEF.md
# Ordered byte-merge read forwarder

This block answers a line read from one speculative thread on a chip where several threads run ahead of each other. Each thread keeps its uncommitted stores in a per-thread write buffer. When a thread reads a line, it must see the committed copy from the shared second-level cache. It must also see every store made by itself and by threads that come before it in program order. It must not see stores made by threads that come after it.

The block takes the cache line, and the hit flag, data line and byte-enable mask from every write buffer. It also takes a speculation rank for each buffer and the identity of the requesting thread. Ranks run from 0 for the least speculative thread upward and form a permutation. A buffer may contribute only if it hit on the address and its rank does not exceed the requester's rank.

For each byte on its own, the block picks the highest-ranked eligible buffer that wrote that byte. If no such buffer exists, it keeps the cache byte. The merged line is registered and presented one clock later with a single-cycle valid strobe.

Top module: `specread_merge`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid` is 0 and `rsp_line` is all zeros until the first request is served.
- R2: Every clock edge with `req_valid` high produces `rsp_valid` high in the following cycle. A cycle after an edge with `req_valid` low has `rsp_valid` low.
- R3: When no eligible buffer has a mask bit set for a byte, that byte of `rsp_line` equals the matching byte of the `l2_line` captured with the request. With no eligible hit at all, the whole line passes through unchanged.
- R4: A buffer whose `buf_hit` bit is 0 never supplies a byte, whatever its mask and data.
- R5: A buffer whose rank is greater than the requester's rank never supplies a byte.
- R6: Selection is done per byte. Mask bit `k*LINE_BYTES+b` of `buf_mask` enables byte b of buffer k. That byte sits at `buf_data[(k*LINE_BYTES+b)*8 +: 8]` and lands in `rsp_line[b*8 +: 8]`. Byte b of `l2_line` is `l2_line[b*8 +: 8]`.
- R7: Among the eligible buffers with the byte's mask bit set, the one with the greatest rank supplies the byte. The rank of buffer k is `buf_rank[k*RANK_W +: RANK_W]`, and 0 is the least speculative.
- R8: If the requester's own buffer (index `req_id`) hits and its mask bit for a byte is set, that byte comes from the requester's own buffer.
- R9: Between requests `rsp_line` holds its last value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A read request is presented this cycle |
| req_id | input | ID_W | Index of the requesting thread and its buffer |
| buf_rank | input | NUM_BUF*RANK_W | Speculation rank of each buffer, 0 = least speculative |
| l2_line | input | LINE_BYTES*8 | Committed line read from the cache |
| buf_hit | input | NUM_BUF | Per-buffer address hit |
| buf_data | input | NUM_BUF*LINE_BYTES*8 | Per-buffer line data |
| buf_mask | input | NUM_BUF*LINE_BYTES | Per-buffer byte write mask |
| rsp_valid | output | 1 | Merged line is valid this cycle |
| rsp_line | output | LINE_BYTES*8 | Merged line |

## Verification
The bench sweeps every requester, every one of the 24 rank orders and every hit pattern. The bytes of the line are set up so that each byte position carries a different one of the 16 possible mask combinations. Because of this, one request covers every overlap case at once.

A design that compares against buffer index instead of rank would fail as soon as the order is not the identity. A design that lets later threads through would leak future stores into earlier readers. One that ignores the hit flag would forward stale buffer bytes. One that picks the lowest rank would return older stores over the requester's own.

After each response, the bench drives changed inputs with no request and checks that the line and the strobe hold.

// File: rtl/specread_pkg.sv
package specread_pkg;
    typedef logic [7:0] byte_t;

    // Rank of buffer k out of a flat rank vector.
    function automatic int unsigned rank_at(input logic [31:0] flat, input int unsigned k,
                                            input int unsigned w);
        int unsigned r;
        r = 0;
        for (int unsigned i = 0; i < w; i++) begin
            r[i] = flat[k*w + i];
        end
        return r;
    endfunction
endpackage

// File: rtl/specread_eligible.sv
module specread_eligible #(
    parameter int NUM_BUF = 4,
    parameter int RANK_W  = 2,
    parameter int ID_W    = 2
) (
    input  logic [ID_W-1:0]           req_id,
    input  logic [NUM_BUF*RANK_W-1:0] buf_rank,
    input  logic [NUM_BUF-1:0]        buf_hit,
    output logic [NUM_BUF-1:0]        eligible
);
    logic [RANK_W-1:0] req_rank;

    always_comb begin
        req_rank = '0;
        for (int k = 0; k < NUM_BUF; k++) begin
            if (req_id == ID_W'(k)) begin
                req_rank = buf_rank[k*RANK_W +: RANK_W];
            end
        end
    end

    // A buffer may forward only if it hit and is not ahead of the requester.
    for (genvar k = 0; k < NUM_BUF; k++) begin : g_elig
        assign eligible[k] = buf_hit[k] && (buf_rank[k*RANK_W +: RANK_W] <= req_rank);
    end
endmodule

// File: rtl/specread_byte_pick.sv
module specread_byte_pick
    import specread_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int RANK_W  = 2
) (
    input  logic [NUM_BUF-1:0]        eligible,
    input  logic [NUM_BUF-1:0]        wmask,
    input  logic [NUM_BUF*RANK_W-1:0] buf_rank,
    input  logic [NUM_BUF*8-1:0]      buf_byte,
    input  byte_t                     base_byte,
    output byte_t                     out_byte
);
    logic [NUM_BUF-1:0] cand;
    logic               found;
    logic [RANK_W-1:0]  best_rank;

    assign cand = eligible & wmask;

    // Priority encode by rank: the latest eligible writer wins, cache is the fallback.
    always_comb begin
        found     = 1'b0;
        best_rank = '0;
        out_byte  = base_byte;
        for (int k = 0; k < NUM_BUF; k++) begin
            if (cand[k] && (!found || (buf_rank[k*RANK_W +: RANK_W] > best_rank))) begin
                found     = 1'b1;
                best_rank = buf_rank[k*RANK_W +: RANK_W];
                out_byte  = buf_byte[k*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/specread_merge.sv
module specread_merge
    import specread_pkg::*;
#(
    parameter int NUM_BUF    = 4,
    parameter int LINE_BYTES = 32,
    parameter int ID_W       = $clog2(NUM_BUF),
    parameter int RANK_W     = ID_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic [ID_W-1:0]                    req_id,
    input  logic [NUM_BUF*RANK_W-1:0]          buf_rank,
    input  logic [LINE_BYTES*8-1:0]            l2_line,
    input  logic [NUM_BUF-1:0]                 buf_hit,
    input  logic [NUM_BUF*LINE_BYTES*8-1:0]    buf_data,
    input  logic [NUM_BUF*LINE_BYTES-1:0]      buf_mask,
    output logic                               rsp_valid,
    output logic [LINE_BYTES*8-1:0]            rsp_line
);
    localparam int LINE_W = LINE_BYTES * 8;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
    } state_t;

    state_t             st_d, st_q;
    logic [NUM_BUF-1:0] eligible;
    logic [LINE_W-1:0]  merged;

    specread_eligible #(
        .NUM_BUF (NUM_BUF),
        .RANK_W  (RANK_W),
        .ID_W    (ID_W)
    ) u_elig (
        .req_id   (req_id),
        .buf_rank (buf_rank),
        .buf_hit  (buf_hit),
        .eligible (eligible)
    );

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        logic [NUM_BUF-1:0]   wmask_b;
        logic [NUM_BUF*8-1:0] bytes_b;
        byte_t                pick_b;

        for (genvar k = 0; k < NUM_BUF; k++) begin : g_slice
            assign wmask_b[k]         = buf_mask[k*LINE_BYTES + b];
            assign bytes_b[k*8 +: 8]  = buf_data[(k*LINE_BYTES + b)*8 +: 8];
        end

        specread_byte_pick #(
            .NUM_BUF (NUM_BUF),
            .RANK_W  (RANK_W)
        ) u_pick (
            .eligible  (eligible),
            .wmask     (wmask_b),
            .buf_rank  (buf_rank),
            .buf_byte  (bytes_b),
            .base_byte (l2_line[b*8 +: 8]),
            .out_byte  (pick_b)
        );

        assign merged[b*8 +: 8] = pick_b;
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.line = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_line  = st_q.line;
endmodule

// File: rtl/specread_merge_chk.sv
module specread_merge_chk #(
    parameter int NUM_BUF    = 4,
    parameter int LINE_BYTES = 32,
    parameter int ID_W       = 2,
    parameter int RANK_W     = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [ID_W-1:0]                 req_id,
    input  logic [LINE_BYTES*8-1:0]         l2_line,
    input  logic [NUM_BUF-1:0]              buf_hit,
    input  logic [NUM_BUF*LINE_BYTES*8-1:0] buf_data,
    input  logic [NUM_BUF*LINE_BYTES-1:0]   buf_mask,
    input  logic                            rsp_valid,
    input  logic [LINE_BYTES*8-1:0]         rsp_line
);
    AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2

    AST_NO_HIT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (buf_hit == '0)) |=> (rsp_line == $past(l2_line))); // R3

    AST_OWN_BYTE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && buf_hit[req_id] && buf_mask[req_id*LINE_BYTES])
        |=> (rsp_line[7:0] == $past(buf_data[req_id*LINE_BYTES*8 +: 8]))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_line)); // R9
endmodule

bind specread_merge specread_merge_chk #(
    .NUM_BUF    (NUM_BUF),
    .LINE_BYTES (LINE_BYTES),
    .ID_W       (ID_W),
    .RANK_W     (RANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_id    (req_id),
    .l2_line   (l2_line),
    .buf_hit   (buf_hit),
    .buf_data  (buf_data),
    .buf_mask  (buf_mask),
    .rsp_valid (rsp_valid),
    .rsp_line  (rsp_line)
);

// File: tb/specread_merge_test.sv
module specread_merge_test;
    localparam int NB = 4;
    localparam int LB = 16;
    localparam int IW = 2;
    localparam int RW = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [IW-1:0]      req_id = '0;
    logic [NB*RW-1:0]   buf_rank = '0;
    logic [LB*8-1:0]    l2_line = '0;
    logic [NB-1:0]      buf_hit = '0;
    logic [NB*LB*8-1:0] buf_data = '0;
    logic [NB*LB-1:0]   buf_mask = '0;
    logic               rsp_valid;
    logic [LB*8-1:0]    rsp_line;

    int checks = 0;
    int errors = 0;
    int rk [NB];

    always #10 clk = ~clk;

    specread_merge #(.NUM_BUF(NB), .LINE_BYTES(LB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .buf_rank(buf_rank), .l2_line(l2_line), .buf_hit(buf_hit),
        .buf_data(buf_data), .buf_mask(buf_mask),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line)
    );

    task automatic check_line(input string tag, input logic [LB*8-1:0] act,
                              input logic [LB*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s line act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s bit act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Byte b of buffer k is 0x10*(k+1)+b; cache byte b is 0xF0+b.
    // Mask bit for buffer k at byte b is bit k of b, so the 16 bytes cover all overlaps (R6).
    task automatic load_fixed();
        for (int b = 0; b < LB; b++) begin
            l2_line[b*8 +: 8] = 8'(8'hF0 + b);
            for (int k = 0; k < NB; k++) begin
                buf_data[(k*LB + b)*8 +: 8] = 8'(16*(k+1) + b);
                buf_mask[k*LB + b] = 1'((b >> k) & 1);
            end
        end
    endtask

    function automatic logic [LB*8-1:0] model(input int req, input logic [NB-1:0] hit);
        logic [LB*8-1:0] r;
        for (int b = 0; b < LB; b++) begin
            int best = -1;
            r[b*8 +: 8] = 8'(8'hF0 + b);
            for (int k = 0; k < NB; k++) begin
                // R4 hit, R5 rank not ahead, R7 greatest rank wins
                if (hit[k] && rk[k] <= rk[req] && ((b >> k) & 1) == 1 && rk[k] > best) begin
                    best = rk[k];
                    r[b*8 +: 8] = 8'(16*(k+1) + b);
                end
            end
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        load_fixed();
        repeat (3) @(negedge clk);
        check_bit("R1 valid in reset", rsp_valid, 1'b0);
        check_line("R1 line in reset", rsp_line, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 valid after reset", rsp_valid, 1'b0);
        check_line("R1 line after reset", rsp_line, '0);

        for (int a = 0; a < NB; a++)
        for (int bb = 0; bb < NB; bb++)
        for (int c = 0; c < NB; c++)
        for (int d = 0; d < NB; d++) begin
            if (a != bb && a != c && a != d && bb != c && bb != d && c != d) begin
                rk[0] = a; rk[1] = bb; rk[2] = c; rk[3] = d;
                for (int req = 0; req < NB; req++) begin
                    for (int h = 0; h < 16; h++) begin
                        logic [LB*8-1:0] exp;
                        logic [LB*8-1:0] held;
                        string tag;
                        load_fixed();
                        for (int k = 0; k < NB; k++) buf_rank[k*RW +: RW] = RW'(rk[k]);
                        req_id    = IW'(req);
                        buf_hit   = NB'(h);
                        req_valid = 1'b1;
                        exp = model(req, NB'(h));
                        tag = (h == 0) ? "R3 no hit" : "R4 R5 R6 R7 R8 merge";
                        @(negedge clk);
                        check_bit("R2 strobe", rsp_valid, 1'b1);
                        check_line(tag, rsp_line, exp);
                        // own byte b=1<<req is written only by requester's buffer (R8)
                        if (h[req]) begin
                            checks++;
                            if (rsp_line[(1 << req)*8 +: 8] !== 8'(16*(req+1) + (1 << req))) begin
                                errors++;
                                $display("FAIL R8 own byte act=%h exp=%h",
                                         rsp_line[(1 << req)*8 +: 8], 8'(16*(req+1) + (1 << req)));
                            end
                        end
                        // idle cycle with disturbed inputs (R9)
                        held      = rsp_line;
                        req_valid = 1'b0;
                        l2_line   = ~l2_line;
                        buf_hit   = ~buf_hit;
                        buf_mask  = ~buf_mask;
                        @(negedge clk);
                        check_bit("R2 strobe drops", rsp_valid, 1'b0);
                        check_line("R9 hold", rsp_line, held);
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule